// File: doc/BRIEF.md
# Page Translation Table Unit

This block keeps a table of 512 page descriptors and uses it to turn a virtual address into a real address. The upper part of the virtual address, the page index, selects one descriptor. The lower part, the offset, passes through unchanged. The lookup is purely combinational, so the real address is ready in the same cycle as the request. Memory accesses that need translation therefore take no extra cycle.

Each descriptor is a 17-bit word. It holds a 13-bit real page number, three status flags and one parity bit. The first flag marks the page as written. The second marks it as referenced. The third marks the descriptor as usable. A program-side port writes whole descriptor images into the table and reads them back, one entry per cycle. This is how the table is loaded from memory and saved to it. On a successful access the block sets the referenced and written flags by itself. An access through an unusable descriptor raises a paging-fault request instead. An access through a descriptor with bad parity raises a parity-error indication instead.

Top module: `page_xlate_unit`

## Requirements
- R1: A program write (`prg_we`) stores the 17-bit image `prg_wdata` unchanged at `prg_addr`. The image is visible on `prg_rdata` from the next cycle, and `prg_rdata` always shows the entry at `prg_addr` combinationally. Bit layout: [12:0] real page, 13 written flag, 14 referenced flag, 15 usable flag, 16 parity.
- R2: With `xl_req` high, good parity and the usable flag set, `xl_ok` is high in the same cycle. `xl_raddr` equals the real page joined above the 11-bit `xl_off`.
- R3: With `xl_req` high, good parity and the usable flag clear, `xl_pgint` is high and `xl_ok` and `xl_raddr` stay low.
- R4: Parity is odd over all 17 bits. With `xl_req` high and an entry whose 17 bits hold an even count of ones, `xl_parerr` is high and `xl_ok` and `xl_pgint` stay low.
- R5: A successful read access (`xl_wr` low) sets the referenced flag of the entry at the next edge and leaves the written flag as it was.
- R6: A successful write access (`xl_wr` high) sets both the referenced flag and the written flag of the entry at the next edge.
- R7: A failed access, whether a paging fault or a parity error, leaves the entry unchanged.
- R8: A hardware flag update never changes the usable flag or the real page, and it rewrites the parity bit so the entry keeps odd parity.
- R9: If a program write and a flag update target the same entry in the same cycle, the entry ends up holding the program's image.
- R10: While `rst_n` is low, `xl_ok`, `xl_pgint`, `xl_parerr` and `xl_raddr` are low, and neither port changes the table.
- R11: With `xl_req` low, all translate outputs are low and the table is not touched by the translate side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prg_we | input | 1 | Program write strobe |
| prg_addr | input | 9 | Program-side entry index |
| prg_wdata | input | 17 | Descriptor image to store |
| prg_rdata | output | 17 | Descriptor image at `prg_addr` |
| xl_req | input | 1 | Translation request |
| xl_wr | input | 1 | Access is a write |
| xl_vpage | input | 9 | Virtual page index |
| xl_off | input | 11 | Page offset |
| xl_raddr | output | 24 | Translated real address |
| xl_ok | output | 1 | Translation succeeded |
| xl_pgint | output | 1 | Paging-fault interrupt request |
| xl_parerr | output | 1 | Descriptor parity error |

## Verification
A wrongly updated descriptor does not show at once. It shows at the ports the first time the entry is used again. A parity bit that was not regenerated raises `xl_parerr` on the next lookup of that entry. A flag left clear or set by mistake shows on `prg_rdata` in the cycle after the access. The bench therefore reads an entry back through the program port right after each interesting access. Its random phase reuses a small set of pages so that each corruption is seen within a few cycles.

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 11,
  parameter int PAGE_W = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prg_we,
  input  logic [IDX_W-1:0]         prg_addr,
  input  logic [PAGE_W+3:0]        prg_wdata,
  output logic [PAGE_W+3:0]        prg_rdata,
  input  logic                     xl_req,
  input  logic                     xl_wr,
  input  logic [IDX_W-1:0]         xl_vpage,
  input  logic [OFF_W-1:0]         xl_off,
  output logic [PAGE_W+OFF_W-1:0]  xl_raddr,
  output logic                     xl_ok,
  output logic                     xl_pgint,
  output logic                     xl_parerr
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int DATA_W = PAGE_W + 3;
  localparam int WORD_W = DATA_W + 1;
  localparam int W_BIT  = PAGE_W;
  localparam int G_BIT  = PAGE_W + 1;
  localparam int U_BIT  = PAGE_W + 2;

  logic [WORD_W-1:0] tbl [DEPTH];
  logic [WORD_W-1:0] ent;
  logic [DATA_W-1:0] upd_data;
  logic [WORD_W-1:0] upd_word;
  logic              req, par_bad, upd_en, clash;

  assign ent     = tbl[xl_vpage];
  assign req     = xl_req & rst_n;
  assign par_bad = ~(^ent);

  assign xl_parerr = req & par_bad;
  assign xl_pgint  = req & ~par_bad & ~ent[U_BIT];
  assign xl_ok     = req & ~par_bad & ent[U_BIT];
  assign xl_raddr  = xl_ok ? {ent[PAGE_W-1:0], xl_off} : '0;

  always_comb begin
    upd_data        = ent[DATA_W-1:0];
    upd_data[G_BIT] = 1'b1;
    if (xl_wr) upd_data[W_BIT] = 1'b1;
  end
  assign upd_word = {~(^upd_data), upd_data};

  assign clash  = prg_we & (prg_addr == xl_vpage);
  assign upd_en = xl_ok & ~clash;

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (upd_en) tbl[xl_vpage] <= upd_word;
      if (prg_we) tbl[prg_addr] <= prg_wdata;
    end
  end

  assign prg_rdata = tbl[prg_addr];

  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xl_ok, xl_pgint, xl_parerr}));

  p_offset_passes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xl_ok |-> xl_raddr[OFF_W-1:0] == xl_off);

  p_no_update_on_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_ok |-> !upd_en);

  p_update_odd_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (^upd_word) == 1'b1);

  p_update_keeps_usable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> upd_word[U_BIT] && upd_word[PAGE_W-1:0] == ent[PAGE_W-1:0]);

  p_program_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_we && prg_addr == xl_vpage) |-> !upd_en);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |-> !xl_ok && !xl_pgint && !xl_parerr && xl_raddr == '0);
endmodule

// File: tb/tb_page_xlate_unit.sv
`timescale 1ns/1ps
module tb_page_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prg_we = 1'b0;
  logic [8:0]  prg_addr = '0;
  logic [16:0] prg_wdata = '0;
  logic [16:0] prg_rdata;
  logic        xl_req = 1'b0, xl_wr = 1'b0;
  logic [8:0]  xl_vpage = '0;
  logic [10:0] xl_off = '0;
  logic [23:0] xl_raddr;
  logic        xl_ok, xl_pgint, xl_parerr;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [16:0] mdl [512];

  always #2.5 clk = ~clk;

  page_xlate_unit dut (
    .clk(clk), .rst_n(rst_n), .prg_we(prg_we), .prg_addr(prg_addr),
    .prg_wdata(prg_wdata), .prg_rdata(prg_rdata), .xl_req(xl_req),
    .xl_wr(xl_wr), .xl_vpage(xl_vpage), .xl_off(xl_off),
    .xl_raddr(xl_raddr), .xl_ok(xl_ok), .xl_pgint(xl_pgint),
    .xl_parerr(xl_parerr));

  function automatic logic [16:0] make_entry(int i);
    logic [15:0] d;
    logic p;
    d = 16'((i * 37 + 5) & 16'h1FFF);
    if (i % 3 == 0) d[13] = 1'b1;
    if (i % 7 == 0) d[14] = 1'b1;
    if (i % 5 != 0) d[15] = 1'b1;
    p = ~(^d);
    if (i % 11 == 0) p = ~p;
    return {p, d};
  endfunction

  task automatic step(string tag, bit we, int a, logic [16:0] wd,
                      bit rq, bit wr, int vp, int off);
    logic [16:0] e;
    logic [15:0] nd;
    bit ebad, eok, epg, eperr;
    logic [23:0] era;
    string t;
    @(negedge clk);
    prg_we = we; prg_addr = 9'(a); prg_wdata = wd;
    xl_req = rq; xl_wr = wr; xl_vpage = 9'(vp); xl_off = 11'(off);
    #1;
    e = mdl[vp];
    ebad = ~(^e);
    eok = rq && !ebad && e[15];
    epg = rq && !ebad && !e[15];
    eperr = rq && ebad;
    era = eok ? {e[12:0], 11'(off)} : 24'd0;
    t = tag;
    if (t == "") t = eperr ? "R4" : epg ? "R3" : eok ? (wr ? "R6" : "R5") : "R11";
    checks++;
    if (xl_ok !== eok || xl_pgint !== epg || xl_parerr !== eperr || xl_raddr !== era) begin
      errors++;
      $display("FAIL %s translate ok/pg/par/raddr got %b%b%b %h expected %b%b%b %h",
               t, xl_ok, xl_pgint, xl_parerr, xl_raddr, eok, epg, eperr, era);
    end
    checks++;
    if (prg_rdata !== mdl[a]) begin
      errors++;
      $display("FAIL %s readback entry %0d got %h expected %h",
               (tag == "") ? "R1" : tag, a, prg_rdata, mdl[a]);
    end
    @(posedge clk);
    if (eok && !(we && a == vp)) begin
      nd = e[15:0];
      nd[14] = 1'b1;
      if (wr) nd[13] = 1'b1;
      mdl[vp] = {~(^nd), nd};
    end
    if (we) mdl[a] = wd;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [16:0] img;
    // R10: reset holds translate outputs low even with a request
    xl_req = 1'b1; xl_vpage = 9'd3; prg_we = 1'b1; prg_wdata = 17'h1FFFF;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (xl_ok !== 1'b0 || xl_pgint !== 1'b0 || xl_parerr !== 1'b0 || xl_raddr !== 24'd0) begin
      errors++;
      $display("FAIL R10 reset outputs got %b%b%b %h expected 000 0",
               xl_ok, xl_pgint, xl_parerr, xl_raddr);
    end
    @(negedge clk);
    xl_req = 1'b0; prg_we = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < 512; i++) step("R1", 1'b1, i, make_entry(i), 1'b0, 1'b0, 0, 0);
    step("R1", 1'b0, 2, '0, 1'b0, 1'b0, 0, 0);

    step("R2", 1'b0, 1, '0, 1'b1, 1'b0, 1, 11'h5A5);
    step("R5", 1'b0, 1, '0, 1'b0, 1'b0, 0, 0);
    step("R6", 1'b0, 2, '0, 1'b1, 1'b1, 2, 11'h7FF);
    step("R6", 1'b0, 2, '0, 1'b0, 1'b0, 0, 0);
    step("R8", 1'b0, 2, '0, 1'b1, 1'b0, 2, 11'h001);
    step("R3", 1'b0, 5, '0, 1'b1, 1'b1, 5, 11'h123);
    step("R7", 1'b0, 5, '0, 1'b0, 1'b0, 0, 0);
    step("R4", 1'b0, 11, '0, 1'b1, 1'b1, 11, 11'h321);
    step("R7", 1'b0, 11, '0, 1'b0, 1'b0, 0, 0);
    img = make_entry(4);
    step("R9", 1'b1, 3, img, 1'b1, 1'b1, 3, 11'h0F0);
    step("R9", 1'b0, 3, '0, 1'b1, 1'b0, 3, 11'h0F0);
    step("R11", 1'b0, 6, '0, 1'b0, 1'b1, 6, 11'h3FF);
    step("R11", 1'b0, 6, '0, 1'b0, 1'b0, 0, 0);
    step("R2", 1'b0, 511, '0, 1'b1, 1'b0, 511, 11'h400);

    for (int k = 0; k < 4000; k++) begin
      int vp, a;
      bit we;
      logic [16:0] wd;
      vp = int'($urandom_range(0, 23));
      a = ($urandom_range(0, 3) == 0) ? vp : int'($urandom_range(0, 23));
      we = ($urandom_range(0, 5) == 0);
      wd = make_entry(int'($urandom_range(0, 511)));
      step("", we, a, wd, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           vp, int'($urandom_range(0, 2047)));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule